// File: doc/BRIEF.md
# Dual-Frame Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that a small processor controls through three byte-wide register addresses: control, data and status. One data address serves both directions. A write to it loads the transmit shifter and starts a frame at once. A read from it returns the last accepted receive byte, which sits in a holding latch. Transmit data can never be read back. The transmitter and the receiver run at the same time and do not depend on each other.

Bit timing comes from `tick_i`, a one-cycle strobe at sixteen times the bit rate, so no baud generator is part of the block. Two frame formats exist. The short format carries eight data bits. The long format adds a ninth bit: on transmit it comes from a control bit, and on receive it is stored into another control bit. In the long format, a multiprocessor filter can drop every frame whose ninth bit is 0. The transmit-complete and receive-complete flags are set only by hardware and cleared only by software. While interrupts are enabled, these flags drive `irq_o`.

Top module: `uart_core`

## Requirements
- R1: After reset, `txd_o` is 1, `irq_o` is 0, and reads of the control, status and data addresses all return 0.
- R2: A write to the data address (`addr_i`=1) starts a frame on `txd_o` within one cycle. The frame is a 0 start bit, the data bits LSB first and a 1 stop bit. Each bit lasts 16 ticks. With the long-format bit (control bit 6) clear, the frame is 10 bits long.
- R3: With control bit 6 set, the transmit frame carries a ninth bit after the eight data bits. Its value is control bit 2.
- R4: Control bit 0 is set when the stop bit of a transmit frame ends. Writing 0 to that bit at the control address (`addr_i`=0) clears it. Writing 1 to it has no effect.
- R5: While control bit 4 is set, a received frame puts its byte into the holding latch, readable at the data address, and sets control bit 1. Writing 0 to control bit 1 clears it. While control bit 4 is clear, incoming frames are ignored.
- R6: Read-only control bit 3 takes the received ninth bit in the long format. In the short format it takes the received stop-bit level.
- R7: With control bits 6 and 5 both set, a received frame whose ninth bit is 0 changes neither the latch, nor control bit 1, nor control bit 3.
- R8: A low pulse on `rxd_i` that has ended before mid-bit is rejected as a false start and produces no byte.
- R9: Each received bit is decided by a majority vote of three samples around mid-bit, so one short glitch does not corrupt it.
- R10: The latch keeps the previous byte while the next frame is being received. If a byte is accepted while control bit 1 is still set, the latch is overwritten and status bit 0 (`addr_i`=2) is set. Writing 0 to status bit 0 clears it.
- R11: `irq_o` is 1 exactly when control bit 7 is set and control bit 0 or control bit 1 is set.
- R12: Transmission and reception can overlap in time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Strobe at 16x the bit rate |
| rxd_i | input | 1 | Serial receive line, idles high |
| txd_o | output | 1 | Serial transmit line, idles high |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 control, 1 data, 2 status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A transmit shifter or bit counter in the wrong state shows up on `txd_o` within one bit time. It appears as a misplaced start bit, a wrong ninth bit, or a frame of the wrong length. It then shows in bit 0 of the control register, which rises too early or too late. A wrong receiver state, such as a skipped start check, a bad vote or a filter that fails to drop a frame, shows up at the stop bit of the frame concerned. The flag, the latch or status bit 0 then disagrees with the bytes sent. The bench feeds `rxd_i` with frames, false starts and glitches whose correct outcome is known. It decodes `txd_o` against a queue of the frames written.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned REG_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  // control register bit positions
  localparam int unsigned C_TXF = 0;
  localparam int unsigned C_RXF = 1;
  localparam int unsigned C_TB8 = 2;
  localparam int unsigned C_RB8 = 3;
  localparam int unsigned C_REN = 4;
  localparam int unsigned C_MPE = 5;
  localparam int unsigned C_M9  = 6;
  localparam int unsigned C_IE  = 7;

  typedef enum logic {RX_IDLE = 1'b0, RX_RUN = 1'b1} rx_st_e;
endpackage

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int unsigned DW  = 8,
  parameter int unsigned OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          nine_i,
  input  logic          bit8_i,
  output logic          txd_o,
  output logic          done_o
);
  localparam int unsigned FW = DW + 3;
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned NW = $clog2(FW + 1);

  logic [FW-1:0] sh_q;
  logic [CW-1:0] os_q;
  logic [NW-1:0] left_q;
  logic          busy_q;
  logic          bit_end;

  assign bit_end = busy_q && tick_i && (os_q == CW'(OSR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      os_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= nine_i ? {1'b1, bit8_i, data_i, 1'b0} : {2'b11, data_i, 1'b0};
      left_q <= nine_i ? NW'(FW) : NW'(FW - 1);
      os_q   <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (bit_end) begin
        os_q   <= '0;
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - NW'(1);
        if (left_q == NW'(1)) busy_q <= 1'b0;
      end else begin
        os_q <= os_q + CW'(1);
      end
    end
  end

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign done_o = bit_end && (left_q == NW'(1)) && !load_i;

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !txd_o);
  assert_end_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(tick_i));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned OSR = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          en_i,
  input  logic          nine_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          bit8_o
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned IW  = $clog2(DW + 3);
  localparam int unsigned MID = OSR / 2 - 1;

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_st_e        st_q;
  logic [CW-1:0] os_q;
  logic [IW-1:0] idx_q;
  logic [DW:0]   sr_q;
  logic          v0_q, v1_q, valid_q;
  logic          vote;
  logic [IW-1:0] last_idx;

  assign rx_s     = sync_q[1];
  assign vote     = (v0_q & v1_q) | (v0_q & rx_s) | (v1_q & rx_s);
  assign last_idx = nine_i ? IW'(DW + 2) : IW'(DW + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      sr_q    <= '0;
      v0_q    <= 1'b1;
      v1_q    <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_i) begin
        if (st_q == RX_IDLE) begin
          if (en_i && !rx_s) begin
            st_q  <= RX_RUN;
            os_q  <= CW'(1);
            idx_q <= '0;
          end
        end else begin
          if (os_q == CW'(OSR - 1)) begin
            os_q  <= '0;
            idx_q <= idx_q + IW'(1);
          end else begin
            os_q <= os_q + CW'(1);
          end
          if (os_q == CW'(MID))     v0_q <= rx_s;
          if (os_q == CW'(MID + 1)) v1_q <= rx_s;
          if (os_q == CW'(MID + 2)) begin
            if (idx_q == '0) begin
              if (vote) st_q <= RX_IDLE;  // false start
            end else begin
              if (idx_q <= IW'(DW + 1)) sr_q <= {vote, sr_q[DW:1]};
              if (idx_q == last_idx) begin
                valid_q <= 1'b1;
                st_q    <= RX_IDLE;
              end
            end
          end
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = sr_q[DW-1:0];
  assign bit8_o  = sr_q[DW];

  assert_valid_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(tick_i));
  assert_no_start_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == RX_IDLE) && (st_q == RX_RUN) |-> $past(en_i));
endmodule

// File: rtl/uart_core.sv
module uart_core
  import uart_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              txd_o,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic          wr_ctrl, wr_data, wr_stat;
  logic          tx_evt, rx_valid, rx_bit8, accept;
  logic [DW-1:0] rx_data;
  logic          txf_q, rxf_q, tb8_q, rb8_q, ren_q, mpe_q, m9_q, ie_q, ovr_q;
  logic [DW-1:0] rbuf_q;
  logic [REG_W-1:0] ctrl_v;

  assign wr_ctrl = wr_i && (addr_i == SEL_CTRL);
  assign wr_data = wr_i && (addr_i == SEL_DATA);
  assign wr_stat = wr_i && (addr_i == SEL_STAT);

  uart_tx #(.DW(DW), .OSR(OSR)) i_tx (
    .clk_i, .rst_ni, .tick_i,
    .load_i (wr_data),
    .data_i (wdata_i),
    .nine_i (m9_q),
    .bit8_i (tb8_q),
    .txd_o,
    .done_o (tx_evt)
  );

  uart_rx #(.DW(DW), .OSR(OSR)) i_rx (
    .clk_i, .rst_ni, .tick_i, .rxd_i,
    .en_i    (ren_q),
    .nine_i  (m9_q),
    .valid_o (rx_valid),
    .data_o  (rx_data),
    .bit8_o  (rx_bit8)
  );

  // multiprocessor filter drops frames with ninth bit 0
  assign accept = rx_valid && !(m9_q && mpe_q && !rx_bit8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {txf_q, rxf_q, tb8_q, rb8_q, ren_q, mpe_q, m9_q, ie_q, ovr_q} <= '0;
      rbuf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        tb8_q <= wdata_i[C_TB8];
        ren_q <= wdata_i[C_REN];
        mpe_q <= wdata_i[C_MPE];
        m9_q  <= wdata_i[C_M9];
        ie_q  <= wdata_i[C_IE];
      end
      if (tx_evt)                          txf_q <= 1'b1;
      else if (wr_ctrl && !wdata_i[C_TXF]) txf_q <= 1'b0;
      if (accept) begin
        rbuf_q <= rx_data;
        rb8_q  <= rx_bit8;
        rxf_q  <= 1'b1;
        if (rxf_q) ovr_q <= 1'b1;
      end else begin
        if (wr_ctrl && !wdata_i[C_RXF]) rxf_q <= 1'b0;
        if (wr_stat && !wdata_i[0])     ovr_q <= 1'b0;
      end
    end
  end

  assign ctrl_v = {ie_q, m9_q, mpe_q, ren_q, rb8_q, tb8_q, rxf_q, txf_q};

  always_comb begin
    unique case (addr_i)
      SEL_CTRL: rdata_o = DW'(ctrl_v);
      SEL_DATA: rdata_o = rbuf_q;
      SEL_STAT: rdata_o = DW'(ovr_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = ie_q && (txf_q || rxf_q);

  assert_txf_sw_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txf_q) |-> $past(wr_ctrl && !wdata_i[C_TXF]));
  assert_rxf_sw_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rxf_q) |-> $past(wr_ctrl && !wdata_i[C_RXF]));
  assert_rxf_set_by_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rxf_q) |-> $past(rx_valid));
  assert_mp_discard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid && m9_q && mpe_q && !rx_bit8 && !rxf_q) |=> !rxf_q);
  assert_overrun_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(rxf_q && rx_valid));
  assert_irq_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_q);
endmodule

// File: tb/test_uart_core.sv
module test_uart_core;
  logic       clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       txd, irq;
  int unsigned checks = 0, fails = 0, tcnt = 0;
  localparam int BIT = 64;  // 16 ticks x 4 clocks

  typedef struct packed {logic [7:0] d; logic nine; logic b8;} txe_t;
  txe_t exp_q[$];

  uart_core i_uart_core (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd), .txd_o(txd),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 3);
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit nine, input logic b8, input int glitch_bit);
    logic [10:0] f;
    int n;
    f = nine ? {1'b1, b8, d, 1'b0} : {2'b11, d, 1'b0};
    n = nine ? 11 : 10;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = f[i];
      if (i == glitch_bit) begin
        repeat (29) @(negedge clk);
        rxd = ~f[i];
        repeat (4) @(negedge clk);
        rxd = f[i];
        repeat (BIT - 34) @(negedge clk);
      end else repeat (BIT - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic tx_byte(input logic [7:0] d, input bit nine, input logic b8);
    txe_t e;
    e.d = d; e.nine = nine; e.b8 = b8;
    exp_q.push_back(e);
    wreg(2'd1, d);
  endtask

  // monitor: decode txd and compare against scoreboard queue
  initial begin
    txe_t e;
    logic [7:0] got;
    logic b8g, st;
    wait (rst_ni);
    forever begin
      @(negedge clk);
      if (txd == 1'b0) begin
        repeat (30) @(negedge clk);
        chk(txd == 1'b0, "R2 start", 16'(txd), 16'h0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = txd;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", 16'(got), 16'hffff);
          e = '0;
        end else e = exp_q.pop_front();
        chk(got == e.d, "R2 data", 16'(got), 16'(e.d));
        if (e.nine) begin
          repeat (BIT) @(negedge clk);
          b8g = txd;
          chk(b8g == e.b8, "R3 ninth", 16'(b8g), 16'(e.b8));
        end
        repeat (BIT) @(negedge clk);
        st = txd;
        chk(st == 1'b1, "R2 stop", 16'(st), 16'h1);
        repeat (BIT / 2) @(negedge clk);
      end
    end
  end

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog", 16'h0, 16'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    #1;
    chk(txd == 1'b1 && irq == 1'b0, "R1 pins", {14'h0, txd, irq}, 16'h2);
    rreg(2'd0, v); chk(v == 8'h00, "R1 ctrl", 16'(v), 16'h0);
    rst_ni = 1'b1;
    rreg(2'd0, v); chk(v == 8'h00, "R1 ctrl", 16'(v), 16'h0);
    rreg(2'd1, v); chk(v == 8'h00, "R1 data", 16'(v), 16'h0);
    rreg(2'd2, v); chk(v == 8'h00, "R1 stat", 16'(v), 16'h0);

    // R2/R4/R11: short-format transmit, flag and interrupt
    wreg(2'd0, 8'h90);
    tx_byte(8'hA5, 1'b0, 1'b0);
    repeat (5 * BIT) @(negedge clk);
    rreg(2'd0, v); chk(v[0] == 1'b0, "R4 flag early", 16'(v), 16'h90);
    repeat (6 * BIT) @(negedge clk);
    rreg(2'd0, v); chk(v == 8'h91, "R4 tx flag", 16'(v), 16'h91);
    chk(irq == 1'b1, "R11 irq on", 16'(irq), 16'h1);
    wreg(2'd0, 8'h13);  // ie off, write 1s to flags
    rreg(2'd0, v); chk(v == 8'h11, "R4 write1 no effect", 16'(v), 16'h11);
    chk(irq == 1'b0, "R11 irq masked", 16'(irq), 16'h0);
    wreg(2'd0, 8'h90);
    rreg(2'd0, v); chk(v == 8'h90, "R4 cleared", 16'(v), 16'h90);
    chk(irq == 1'b0, "R11 irq off", 16'(irq), 16'h0);

    // R3: long format, ninth bit from control bit 2
    wreg(2'd0, 8'h54);
    tx_byte(8'h3C, 1'b1, 1'b1);
    repeat (12 * BIT) @(negedge clk);
    wreg(2'd0, 8'h50);
    tx_byte(8'hC3, 1'b1, 1'b0);
    repeat (12 * BIT) @(negedge clk);
    rreg(2'd0, v); chk(v[0] == 1'b1, "R4 long flag", 16'(v), 16'h51);

    // R5/R6: short-format receive, stop bit into bit 3
    wreg(2'd0, 8'h10);
    rx_frame(8'h5A, 1'b0, 1'b0, -1);
    rreg(2'd0, v); chk(v == 8'h1A, "R6 rx flag stop", 16'(v), 16'h1A);
    rreg(2'd1, v); chk(v == 8'h5A, "R5 rx data", 16'(v), 16'h5A);

    // R6: long format, ninth bit 0
    wreg(2'd0, 8'h50);
    rx_frame(8'h81, 1'b1, 1'b0, -1);
    rreg(2'd0, v); chk(v == 8'h52, "R6 ninth 0", 16'(v), 16'h52);
    rreg(2'd1, v); chk(v == 8'h81, "R6 data", 16'(v), 16'h81);

    // R7: multiprocessor filter
    wreg(2'd0, 8'h70);
    rx_frame(8'h22, 1'b1, 1'b0, -1);
    rreg(2'd0, v); chk(v == 8'h70, "R7 dropped flag", 16'(v), 16'h70);
    rreg(2'd1, v); chk(v == 8'h81, "R7 latch kept", 16'(v), 16'h81);
    rx_frame(8'h33, 1'b1, 1'b1, -1);
    rreg(2'd0, v); chk(v == 8'h7A, "R7 accepted", 16'(v), 16'h7A);
    rreg(2'd1, v); chk(v == 8'h33, "R7 data", 16'(v), 16'h33);

    // R5: receiver disabled
    wreg(2'd0, 8'h00);
    rx_frame(8'h44, 1'b0, 1'b0, -1);
    rreg(2'd0, v); chk(v[1] == 1'b0, "R5 disabled flag", 16'(v), 16'h08);
    rreg(2'd1, v); chk(v == 8'h33, "R5 disabled data", 16'(v), 16'h33);

    // R8: false start
    wreg(2'd0, 8'h10);
    @(negedge clk); rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (20 * BIT) @(negedge clk);
    rreg(2'd0, v); chk(v[1] == 1'b0, "R8 false start", 16'(v), 16'h18);

    // R9: glitch in data bit 2 (value 1)
    rx_frame(8'h0F, 1'b0, 1'b0, 3);
    rreg(2'd1, v); chk(v == 8'h0F, "R9 majority", 16'(v), 16'h0F);
    wreg(2'd0, 8'h10);

    // R10: double buffering and overrun
    rx_frame(8'h11, 1'b0, 1'b0, -1);
    fork
      rx_frame(8'h99, 1'b0, 1'b0, -1);
      begin
        repeat (5 * BIT) @(negedge clk);
        rreg(2'd1, v); chk(v == 8'h11, "R10 latch held", 16'(v), 16'h11);
      end
    join
    rreg(2'd1, v); chk(v == 8'h99, "R10 overwrite", 16'(v), 16'h99);
    rreg(2'd2, v); chk(v == 8'h01, "R10 overrun", 16'(v), 16'h01);
    wreg(2'd2, 8'h00);
    rreg(2'd2, v); chk(v == 8'h00, "R10 overrun clear", 16'(v), 16'h00);

    // R12: simultaneous transmit and receive
    wreg(2'd0, 8'h10);
    fork
      tx_byte(8'h6E, 1'b0, 1'b0);
      rx_frame(8'h7D, 1'b0, 1'b0, -1);
    join
    repeat (2 * BIT) @(negedge clk);
    rreg(2'd0, v); chk(v == 8'h1B, "R12 both flags", 16'(v), 16'h1B);
    rreg(2'd1, v); chk(v == 8'h7D, "R12 rx data", 16'(v), 16'h7D);
    rreg(2'd2, v); chk(v == 8'h00, "R12 no overrun", 16'(v), 16'h00);

    repeat (2 * BIT) @(negedge clk);
    chk(exp_q.size() == 0, "R2 frames sent", 16'(exp_q.size()), 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule